// File: doc/BRIEF.md
# ADC Result Byte Registers with Coherent Read Lock

This block stores the latest 10-bit analog conversion result and shows it to a processor as two read-only byte registers, one for the lower byte and one for the upper byte. A conversion-complete strobe delivers each new result. One select input chooses how the 10 bits sit across the 16 bit positions: packed toward the bottom (right-aligned) or toward the top (left-aligned). The stored 10-bit value never changes with the select. The select only changes how that value is mapped onto the bytes at read time.

A 10-bit value needs two separate byte reads, and a conversion could land between them. To stop that, a read of the lower byte locks the visible value until the upper byte is read. Results that finish while the lock is held go into a one-entry buffer. Each newer result overwrites the older one, and the buffer moves into the visible register once the upper byte is read. Software that needs only 8 bits selects left alignment and reads the upper byte alone. For differential sources the value is two's complement, so the upper byte then holds the sign plus the 7 most significant magnitude bits.

Top module: `adc_result_latch`

## Requirements
- R1: Synchronous active-high reset clears the stored result, the buffer and the lock, so both bytes read 0x00.
- R2: With `align_left` = 0, result bits 9..8 appear in upper-byte bits 1..0 and upper-byte bits 7..2 read 0. Result bits 7..0 form the lower byte.
- R3: With `align_left` = 1, result bits 9..2 form the upper byte. Result bits 1..0 appear in lower-byte bits 7..6, and lower-byte bits 5..0 read 0.
- R4: When unlocked, a `conv_done` strobe makes `conv_data` visible from the cycle after the strobe.
- R5: A lower-byte read (`rd_en`=1, `rd_addr`=0) locks the visible value from that cycle on. Conversions that complete in that cycle or later do not change what is read until an upper-byte read.
- R6: Results that complete during the lock are buffered, and only the newest is kept. The buffered result becomes visible in the cycle after the upper-byte read (`rd_addr`=1).
- R7: An upper-byte read without a prior lower-byte read does not lock, so a later conversion updates the visible value.
- R8: Changing `align_left` re-maps the same stored result with no new conversion.
- R9: `rd_data` is combinational from `rd_addr`, the select and the stored value, and is valid in the same cycle as the read strobe.
- R10: A two's-complement result is stored unchanged. Left-aligned, the upper byte is the value's sign and 7 MSBs read as a signed byte.
- R11: A conversion completing in the same cycle as the unlocking upper-byte read wins over any buffered result. The read in that cycle still returns the old upper byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| conv_done | input | 1 | One-cycle strobe: new result on `conv_data` |
| conv_data | input | 10 | Conversion result |
| align_left | input | 1 | 0 = right-aligned, 1 = left-aligned |
| rd_en | input | 1 | Byte read strobe |
| rd_addr | input | 1 | 0 = lower byte, 1 = upper byte |
| rd_data | output | 8 | Read data, combinational |

## Verification
The assertions assume `conv_done` and `rd_en` are sampled only at clock edges, and that `rd_addr` selects exactly one byte per cycle. They also assume reset is held for at least one edge before any strobe, so the lock and buffer start from a known state. The stimulus drives every input on the falling edge and holds each strobe for exactly one cycle. It stays within these limits while still placing conversions in the same cycle as both the locking read and the unlocking read.

// File: rtl/adc_result_latch.sv
module adc_result_latch #(
  parameter int RES_W  = 10,
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              conv_done,
  input  logic [RES_W-1:0]  conv_data,
  input  logic              align_left,
  input  logic              rd_en,
  input  logic              rd_addr,
  output logic [BYTE_W-1:0] rd_data
);
  localparam int WORD_W = 2 * BYTE_W;
  localparam int PAD_W  = WORD_W - RES_W;

  logic [RES_W-1:0]  shown, pending;
  logic              pend_vld, locked;
  logic              lo_rd, hi_rd, hold;
  logic [WORD_W-1:0] word;

  assign lo_rd = rd_en & ~rd_addr;
  assign hi_rd = rd_en & rd_addr;
  assign hold  = (locked | lo_rd) & ~hi_rd;

  always_ff @(posedge clk) begin
    if (rst) begin
      shown    <= '0;
      pending  <= '0;
      pend_vld <= 1'b0;
      locked   <= 1'b0;
    end else begin
      if (lo_rd)      locked <= 1'b1;
      else if (hi_rd) locked <= 1'b0;

      if (hold) begin
        if (conv_done) begin
          pending  <= conv_data;
          pend_vld <= 1'b1;
        end
      end else begin
        if (conv_done)     shown <= conv_data;
        else if (pend_vld) shown <= pending;
        pend_vld <= 1'b0;
      end
    end
  end

  assign word    = align_left ? {shown, {PAD_W{1'b0}}} : {{PAD_W{1'b0}}, shown};
  assign rd_data = rd_addr ? word[WORD_W-1:BYTE_W] : word[BYTE_W-1:0];

endmodule

// File: rtl/adc_result_latch_chk.sv
module adc_result_latch_chk #(
  parameter int RES_W  = 10,
  parameter int BYTE_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              conv_done,
  input logic [RES_W-1:0]  conv_data,
  input logic              align_left,
  input logic              rd_en,
  input logic              rd_addr,
  input logic [BYTE_W-1:0] rd_data,
  input logic [RES_W-1:0]  shown,
  input logic [RES_W-1:0]  pending,
  input logic              pend_vld,
  input logic              locked
);
  localparam int PAD_W = 2 * BYTE_W - RES_W;

  logic hi_rd, lo_rd;
  assign hi_rd = rd_en & rd_addr;
  assign lo_rd = rd_en & ~rd_addr;

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (shown == '0 && !locked && !pend_vld));

  // R2
  right_pad_chk: assert property (@(posedge clk) disable iff (rst)
    (!align_left && rd_addr) |-> rd_data[BYTE_W-1 -: PAD_W] == '0);

  // R3
  left_pad_chk: assert property (@(posedge clk) disable iff (rst)
    (align_left && !rd_addr) |-> rd_data[PAD_W-1:0] == '0);

  // R4
  unlocked_update_chk: assert property (@(posedge clk) disable iff (rst)
    (!locked && !lo_rd && conv_done) |=> shown == $past(conv_data));

  // R5
  lock_hold_chk: assert property (@(posedge clk) disable iff (rst)
    ((locked || lo_rd) && !hi_rd) |=> $stable(shown));

  // R6
  pending_release_chk: assert property (@(posedge clk) disable iff (rst)
    (locked && hi_rd && !conv_done && pend_vld) |=> shown == $past(pending));

  // R7
  hi_no_lock_chk: assert property (@(posedge clk) disable iff (rst)
    (!locked && hi_rd) |=> !locked);

  // R11
  release_newest_chk: assert property (@(posedge clk) disable iff (rst)
    (locked && hi_rd && conv_done) |=> shown == $past(conv_data));
endmodule

bind adc_result_latch adc_result_latch_chk #(.RES_W(RES_W), .BYTE_W(BYTE_W)) u_chk (
  .clk(clk), .rst(rst), .conv_done(conv_done), .conv_data(conv_data),
  .align_left(align_left), .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
  .shown(shown), .pending(pending), .pend_vld(pend_vld), .locked(locked)
);

// File: tb/adc_result_latch_tb.sv
`timescale 1ns/1ps
module adc_result_latch_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       conv_done = 1'b0;
  logic [9:0] conv_data = '0;
  logic       align_left = 1'b0;
  logic       rd_en = 1'b0;
  logic       rd_addr = 1'b0;
  logic [7:0] rd_data;

  typedef struct {
    logic [7:0] exp;
    string      tag;
  } item_t;

  item_t exp_q[$];
  int    n_cmp = 0;
  int    n_bad = 0;
  bit    done  = 1'b0;

  always #10 clk = ~clk;

  adc_result_latch u_dut (
    .clk(clk), .rst(rst), .conv_done(conv_done), .conv_data(conv_data),
    .align_left(align_left), .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data)
  );

  // One cycle: optional read with expected value, optional conversion.
  task automatic cyc(input bit rd, input bit a, input logic [7:0] e, input string tag,
                     input bit cv, input logic [9:0] d);
    item_t it;
    @(negedge clk);
    rd_en     = rd;
    rd_addr   = a;
    conv_done = cv;
    conv_data = d;
    if (rd) begin
      it.exp = e;
      it.tag = tag;
      exp_q.push_back(it);
    end
    @(negedge clk);
    rd_en     = 1'b0;
    conv_done = 1'b0;
  endtask

  task automatic rd(input bit a, input logic [7:0] e, input string tag);
    cyc(1'b1, a, e, tag, 1'b0, '0);
  endtask

  task automatic conv(input logic [9:0] d);
    cyc(1'b0, 1'b0, '0, "", 1'b1, d);
  endtask

  // Monitor: samples mid low phase, away from the rising edge.
  initial begin
    forever begin
      @(negedge clk);
      #5;
      if (rd_en) begin
        item_t it;
        it = exp_q.pop_front();
        n_cmp++;
        if (rd_data !== it.exp) begin
          n_bad++;
          $display("FAIL %s: addr=%0d got %02h expected %02h", it.tag, rd_addr, rd_data, it.exp);
        end
      end
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(20 * 20000);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1: reset state
    rd(1'b0, 8'h00, "R1 lower after reset");
    rd(1'b1, 8'h00, "R1 upper after reset");
    // R4, R2, R9: right-aligned update
    conv(10'h2A5);
    rd(1'b0, 8'hA5, "R4 R2 R9 lower right");
    rd(1'b1, 8'h02, "R2 upper right");
    // R3, R8: left alignment re-maps the same value
    align_left = 1'b1;
    rd(1'b1, 8'hA9, "R3 R8 upper left only");
    rd(1'b0, 8'h40, "R3 R8 lower left");
    align_left = 1'b0;
    // R5, R6: lock holds, newest pending wins
    rd(1'b0, 8'hA5, "R5 lower locks");
    conv(10'h13C);
    conv(10'h0F0);
    rd(1'b1, 8'h02, "R5 upper coherent");
    rd(1'b0, 8'hF0, "R6 newest pending lower");
    rd(1'b1, 8'h00, "R6 newest pending upper");
    // R7: upper read alone does not lock
    rd(1'b1, 8'h00, "R7 upper alone");
    conv(10'h3FF);
    rd(1'b0, 8'hFF, "R7 update after upper-only");
    rd(1'b1, 8'h03, "R7 upper");
    // R11: conversion during the unlocking read
    rd(1'b0, 8'hFF, "R11 lower locks");
    conv(10'h0AA);
    cyc(1'b1, 1'b1, 8'h03, "R11 upper old value", 1'b1, 10'h155);
    rd(1'b0, 8'h55, "R11 newest wins lower");
    rd(1'b1, 8'h01, "R11 newest wins upper");
    // R5: conversion in the same cycle as the locking read
    cyc(1'b1, 1'b0, 8'h55, "R5 lower with conv", 1'b1, 10'h200);
    rd(1'b1, 8'h01, "R5 upper stays coherent");
    rd(1'b0, 8'h00, "R6 released lower");
    rd(1'b1, 8'h02, "R6 released upper");
    // R10: signed value, left-aligned
    align_left = 1'b1;
    conv(10'h3F6);
    rd(1'b1, 8'hFD, "R10 signed upper");
    rd(1'b0, 8'h80, "R10 signed lower");
    rd(1'b1, 8'hFD, "R10 R3 upper after lower");
    repeat (2) @(negedge clk);
    if (exp_q.size() != 0) begin
      n_cmp++;
      n_bad++;
      $display("FAIL R9: got %0d unchecked reads expected 0", exp_q.size());
    end
    finish_run();
  end
endmodule